// File: doc/BRIEF.md
# Bi-phase Serial Word Encoder

This block turns 16-bit host words into self-clocking bi-phase frames for a dual-redundant serial bus. Each frame lasts 20 bit times. It opens with a three-bit-long sync shape, then carries 16 Manchester-coded data bits, most significant bit first, and closes with an odd parity bit. The frame goes out on one of two differential logic-level pairs, and the analog drivers beyond those pairs are not part of the block. A host write to the data address starts a frame at once when the encoder is idle. A second-address write sets a per-bus quiet control.

While a frame is going out, one pending word can be parked for the next frame. The host may park it only inside a window that runs from 3.5 to 18.5 bit times after the current frame began. A ready flag in the status word is high during that window and also whenever the encoder is idle. A parked word follows the parity bit of the current frame with no gap, so a message of any length streams out when the host writes once per frame time. The bit rate is set by a parameter giving clocks per half bit. The default of 4 clocks per half bit gives 1 Mbit/s from an 8 MHz clock.

Top module: `manch_tx_encoder`

## Requirements
- R1: After reset, all four line outputs are low and `status` reads 16'h8000: ready (bit 15) is high and both quiet bits (bits 1:0) are low.
- R2: A frame starts with six half-bit slots of sync. A data frame (`sync_cmd`=0) is low for the first three slots and high for the next three. A command frame (`sync_cmd`=1) is high for the first three slots and low for the next three.
- R3: Data bits follow the sync, bit 15 first. A 1 is high in the first half of its bit and low in the second half. A 0 is the reverse.
- R4: The last bit of the frame is odd parity over the 16 data bits, so the frame holds an odd number of ones, and it is Manchester coded like a data bit.
- R5: `chan_sel`, latched with the word at the write, picks the bus: 0 for bus A and 1 for bus B. The other bus keeps both lines low.
- R6: When idle, both lines of both pairs are low. When the parity bit ends and no word is parked, the encoder returns to idle.
- R7: Ready is high while idle. During a frame with no word parked, ready is high only in half-bit slots 7 to 36, which is from 3.5 to 18.5 bit times after the frame starts.
- R8: A data-address write made while ready is low is ignored and does not change the transmitted output.
- R9: A data write made while ready is high during a frame parks the word and drops ready. The parked word's frame starts directly after the current parity bit, with no idle gap.
- R10: A write to address 1 sets the quiet bits from `wr_data[1:0]` (bit 0 for bus A, bit 1 for bus B), and `status[1:0]` reads them back. A quiet bus keeps both lines low, while frame timing and ready behave as usual.
- R11: While a pair is active, its two lines are always complementary, and they are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle |
| wr_addr | input | 1 | 0 = data word, 1 = quiet control |
| wr_data | input | 16 | Write data |
| chan_sel | input | 1 | Bus choice for the written word (0 = A, 1 = B) |
| sync_cmd | input | 1 | Sync shape for the written word (1 = command) |
| status | output | 16 | Bit 15 ready, bits 1:0 quiet bits, others zero |
| bus_a_p | output | 1 | Bus A true line |
| bus_a_n | output | 1 | Bus A complement line |
| bus_b_p | output | 1 | Bus B true line |
| bus_b_n | output | 1 | Bus B complement line |

## Verification
The hardest case to reach from the ports is a chain of three or more frames. In that case each new word has to be parked inside the window of a frame that itself started from a parked word. A timing error at either window edge, or at the frame hand-off, shows up as one wrong half-bit or as a gap. The stimulus issues writes at exact half-bit slots inside the capture loop: at slot 10 of the first frame, at slot 20 of the second, and at slots 3 and 38, which lie just outside the window. Every half-bit slot of both buses is sampled, so one stray slot is caught.

// File: rtl/txe_pkg.sv
package txe_pkg;
  localparam int WORD_W      = 16;
  localparam int FRAME_BITS  = WORD_W + 4;          // 3 sync + data + parity
  localparam int HALVES      = 2 * FRAME_BITS;      // half-bit slots per frame
  localparam int HIDX_W      = $clog2(HALVES);
  localparam int SYNC_HALVES = 6;
  localparam int WIN_OPEN    = 7;                   // 3.5 bit times
  localparam int WIN_CLOSE   = HALVES - 3;          // 18.5 bit times, exclusive

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              cmd;
    logic              chan;
  } txe_word_t;

  typedef enum logic {ST_IDLE, ST_SEND} txe_state_t;
endpackage

// File: rtl/txe_sequencer.sv
module txe_sequencer
  import txe_pkg::*;
#(
  parameter int HALF_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              chan_sel,
  input  logic              sync_cmd,
  output logic              busy,
  output logic [HIDX_W-1:0] hidx,
  output txe_word_t         cur,
  output logic              ready,
  output logic              hold_pending,
  output logic [1:0]        quiet
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

  txe_state_t        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [HIDX_W-1:0] hidx_q, hidx_d;
  txe_word_t         cur_q, cur_d, hold_q, new_word;
  logic              hold_v_q, hold_v_d;
  logic [1:0]        quiet_q;
  logic              half_end, word_end, in_win, data_wr, ctl_wr;
  logic              cur_en, hold_en;

  assign half_end = (cnt_q == CW'(HALF_CLKS - 1));
  assign word_end = half_end && (hidx_q == HIDX_W'(HALVES - 1));
  assign in_win   = (hidx_q >= HIDX_W'(WIN_OPEN)) && (hidx_q < HIDX_W'(WIN_CLOSE));
  assign data_wr  = wr_en && !wr_addr;
  assign ctl_wr   = wr_en && wr_addr;
  assign ready    = (state_q == ST_IDLE) || (in_win && !hold_v_q);
  assign new_word = '{data: wr_data, cmd: sync_cmd, chan: chan_sel};

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    hidx_d   = hidx_q;
    cur_d    = cur_q;
    cur_en   = 1'b0;
    hold_en  = 1'b0;
    hold_v_d = hold_v_q;
    case (state_q)
      ST_IDLE: begin
        if (data_wr) begin
          state_d = ST_SEND;
          cnt_d   = '0;
          hidx_d  = '0;
          cur_d   = new_word;
          cur_en  = 1'b1;
        end
      end
      default: begin
        cnt_d = half_end ? '0 : cnt_q + CW'(1);
        if (half_end) hidx_d = hidx_q + HIDX_W'(1);
        if (data_wr && ready) begin
          hold_en  = 1'b1;
          hold_v_d = 1'b1;
        end
        if (word_end) begin
          hidx_d = '0;
          if (hold_v_q) begin
            cur_d    = hold_q;
            cur_en   = 1'b1;
            hold_v_d = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      hidx_q   <= '0;
      hold_v_q <= 1'b0;
      quiet_q  <= 2'b00;
      cur_q    <= '0;
      hold_q   <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      hidx_q   <= hidx_d;
      hold_v_q <= hold_v_d;
      if (ctl_wr)  quiet_q <= wr_data[1:0];
      if (cur_en)  cur_q   <= cur_d;
      if (hold_en) hold_q  <= new_word;
    end
  end

  assign busy         = (state_q == ST_SEND);
  assign hidx         = hidx_q;
  assign cur          = cur_q;
  assign hold_pending = hold_v_q;
  assign quiet        = quiet_q;
endmodule

// File: rtl/txe_symbol_gen.sv
module txe_symbol_gen
  import txe_pkg::*;
(
  input  logic [HIDX_W-1:0] hidx,
  input  txe_word_t         cur,
  output logic              level
);
  logic [HIDX_W-1:0] off;
  logic [4:0]        pos;
  logic              bitv, first_half, early_sync;

  always_comb begin
    off        = hidx - HIDX_W'(SYNC_HALVES);
    pos        = off[5:1];
    first_half = !hidx[0];
    early_sync = (hidx < HIDX_W'(SYNC_HALVES / 2));
    bitv       = pos[4] ? ~^cur.data : cur.data[~pos[3:0]];
    if (hidx < HIDX_W'(SYNC_HALVES))
      level = cur.cmd ? early_sync : !early_sync;
    else
      level = first_half ? bitv : !bitv;
  end
endmodule

// File: rtl/txe_line_drv.sv
module txe_line_drv #(
  parameter logic BUS_ID = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic chan,
  input  logic quiet,
  input  logic level,
  output logic line_p,
  output logic line_n
);
  logic active, p_d, n_d, p_q, n_q;

  always_comb begin
    active = busy && (chan == BUS_ID) && !quiet;
    p_d    = active && level;
    n_d    = active && !level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= 1'b0;
      n_q <= 1'b0;
    end else begin
      p_q <= p_d;
      n_q <= n_d;
    end
  end

  assign line_p = p_q;
  assign line_n = n_q;
endmodule

// File: rtl/manch_tx_encoder.sv
module manch_tx_encoder
  import txe_pkg::*;
#(
  parameter int HALF_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [15:0] wr_data,
  input  logic        chan_sel,
  input  logic        sync_cmd,
  output logic [15:0] status,
  output logic        bus_a_p,
  output logic        bus_a_n,
  output logic        bus_b_p,
  output logic        bus_b_n
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              busy, ready, level, hold_pending;
  logic [HIDX_W-1:0] hidx;
  txe_word_t         cur;
  logic [1:0]        quiet, lp, ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  txe_sequencer #(.HALF_CLKS(HALF_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .chan_sel(chan_sel), .sync_cmd(sync_cmd),
    .busy(busy), .hidx(hidx), .cur(cur), .ready(ready),
    .hold_pending(hold_pending), .quiet(quiet)
  );

  txe_symbol_gen u_sym (.hidx(hidx), .cur(cur), .level(level));

  for (genvar g = 0; g < 2; g++) begin : g_bus
    txe_line_drv #(.BUS_ID(1'(g))) u_drv (
      .clk(clk), .rst_n(rst_sync_n), .busy(busy), .chan(cur.chan),
      .quiet(quiet[g]), .level(level), .line_p(lp[g]), .line_n(ln[g])
    );
  end

  assign bus_a_p = lp[0];
  assign bus_a_n = ln[0];
  assign bus_b_p = lp[1];
  assign bus_b_n = ln[1];
  assign status  = {ready, 13'd0, quiet};
endmodule

// File: rtl/txe_checker.sv
module txe_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_addr,
  input logic [15:0] status,
  input logic        hold_pending,
  input logic        a_p,
  input logic        a_n,
  input logic        b_p,
  input logic        b_n
);
  AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_p && a_n) && !(b_p && b_n)); // R11
  AST_ONE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !((a_p || a_n) && (b_p || b_n))); // R5
  AST_QUIET_A: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && $past(status[0])) |-> (!a_p && !a_n)); // R10
  AST_QUIET_B: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && $past(status[1])) |-> (!b_p && !b_n)); // R10
  AST_LATE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && !status[15]) |=> !$rose(hold_pending)); // R8
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_pending) |-> !status[15]); // R9
endmodule

bind manch_tx_encoder txe_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .status(status), .hold_pending(hold_pending),
  .a_p(bus_a_p), .a_n(bus_a_n), .b_p(bus_b_p), .b_n(bus_b_n)
);

// File: tb/manch_tx_encoder_test.sv
module manch_tx_encoder_test;
  localparam int HALF = 4;
  logic clk, rst_n, wr_en, wr_addr, chan_sel, sync_cmd;
  logic [15:0] wr_data, status;
  logic bus_a_p, bus_a_n, bus_b_p, bus_b_n;
  int checks, errors;
  bit done;
  logic capAp[0:127], capAn[0:127], capBp[0:127], capBn[0:127], rdy[0:127];

  manch_tx_encoder #(.HALF_CLKS(HALF)) uut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_half(input int h, input logic [15:0] d, input logic cmd);
    int k;
    logic b;
    if (h < 6) return cmd ? (h < 3) : (h >= 3);
    k = (h - 6) / 2;
    b = (k < 16) ? d[15-k] : ~(^d);
    return (h % 2 == 0) ? b : ~b;
  endfunction

  // first write at start; optional extra writes at half slots wh1, wh2
  task automatic run(input int n, input logic [15:0] d0, input int wh1, input logic [15:0] d1,
                     input int wh2, input logic [15:0] d2);
    @(negedge clk);
    wr_en = 1; wr_addr = 0; wr_data = d0;
    @(posedge clk); #1 wr_en = 0;
    repeat (1 + HALF/2) @(posedge clk);
    #1;
    for (int h = 0; h < n; h++) begin
      capAp[h] = bus_a_p; capAn[h] = bus_a_n; capBp[h] = bus_b_p; capBn[h] = bus_b_n;
      rdy[h] = status[15];
      if (h == wh1 || h == wh2) begin
        wr_en = 1; wr_addr = 0; wr_data = (h == wh1) ? d1 : d2;
        @(posedge clk); #1 wr_en = 0;
        repeat (HALF - 1) @(posedge clk);
        #1;
      end else begin
        repeat (HALF) @(posedge clk);
        #1;
      end
    end
  endtask

  task automatic verify_frame(input int base, input logic [15:0] d, input logic cmd, input logic bus);
    int bad_s = 0, bad_d = 0, bad_p = 0, bad_c = 0, bad_o = 0;
    for (int h = 0; h < 40; h++) begin
      logic p, n, op, on, e;
      p  = bus ? capBp[base+h] : capAp[base+h];
      n  = bus ? capBn[base+h] : capAn[base+h];
      op = bus ? capAp[base+h] : capBp[base+h];
      on = bus ? capAn[base+h] : capBn[base+h];
      e  = exp_half(h, d, cmd);
      if (p !== e) begin
        if (h < 6) bad_s++; else if (h < 38) bad_d++; else bad_p++;
      end
      if (n !== ~p) bad_c++;
      if (op !== 1'b0 || on !== 1'b0) bad_o++;
    end
    check(bad_s == 0, "R2 sync shape", bad_s, 0);
    check(bad_d == 0, "R3 data halves", bad_d, 0);
    check(bad_p == 0, "R4 parity halves", bad_p, 0);
    check(bad_c == 0, "R11 complement", bad_c, 0);
    check(bad_o == 0, "R5 other bus idle", bad_o, 0);
  endtask

  task automatic verify_idle(input int from, input int to, input string req);
    int bad = 0;
    for (int h = from; h < to; h++)
      if (capAp[h] | capAn[h] | capBp[h] | capBn[h]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    check(status === 16'h8000, "R1 status", status, 16'h8000);
    check({bus_a_p, bus_a_n, bus_b_p, bus_b_n} === 4'b0, "R1 lines", {bus_a_p, bus_a_n, bus_b_p, bus_b_n}, 0);
  endtask

  task automatic t_single_data();
    int bad = 0;
    chan_sel = 0; sync_cmd = 0;
    run(44, 16'hA5C3, -1, 0, -1, 0);
    verify_frame(0, 16'hA5C3, 0, 0);
    verify_idle(40, 44, "R6 idle after parity");
    for (int h = 0; h < 40; h++)
      if (rdy[h] !== (h >= 7 && h <= 36)) bad++;
    check(bad == 0, "R7 ready window", bad, 0);
    check(rdy[41] === 1'b1, "R7 ready while idle", rdy[41], 1);
  endtask

  task automatic t_cmd_bus_b();
    chan_sel = 1; sync_cmd = 1;
    run(44, 16'h0001, -1, 0, -1, 0);
    verify_frame(0, 16'h0001, 1, 1);
    verify_idle(40, 44, "R6 idle after cmd frame");
    run(44, 16'hFFFE, -1, 0, -1, 0);
    verify_frame(0, 16'hFFFE, 1, 1);
  endtask

  task automatic t_chain3();
    chan_sel = 0; sync_cmd = 0;
    run(124, 16'h1234, 10, 16'hBEEF, 60, 16'h0F0F);
    check(rdy[11] === 1'b0, "R9 ready drops after park", rdy[11], 0);
    verify_frame(0, 16'h1234, 0, 0);
    verify_frame(40, 16'hBEEF, 0, 0);
    verify_frame(80, 16'h0F0F, 0, 0);
    verify_idle(120, 124, "R9 chain ends idle");
  endtask

  task automatic t_ignored();
    chan_sel = 1; sync_cmd = 0;
    run(48, 16'h8001, 3, 16'h7777, 38, 16'h5555);
    check(rdy[3] === 1'b0, "R8 ready low early", rdy[3], 0);
    verify_frame(0, 16'h8001, 0, 1);
    verify_idle(40, 48, "R8 early/late writes ignored");
  endtask

  task automatic t_quiet();
    int bad = 0;
    @(negedge clk); wr_en = 1; wr_addr = 1; wr_data = 16'h0001;
    @(negedge clk); wr_en = 0;
    check(status === 16'h8001, "R10 quiet readback", status, 16'h8001);
    chan_sel = 0; sync_cmd = 0;
    run(44, 16'hC3A5, -1, 0, -1, 0);
    verify_idle(0, 44, "R10 quiet bus A silent");
    for (int h = 0; h < 40; h++)
      if (rdy[h] !== (h >= 7 && h <= 36)) bad++;
    check(bad == 0, "R10 ready timing unchanged", bad, 0);
    chan_sel = 1;
    run(44, 16'h3C5A, -1, 0, -1, 0);
    verify_frame(0, 16'h3C5A, 0, 1);
    @(negedge clk); wr_en = 1; wr_addr = 1; wr_data = 16'h0000;
    @(negedge clk); wr_en = 0;
    check(status === 16'h8000, "R10 quiet cleared", status, 16'h8000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; chan_sel = 0; sync_cmd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_single_data();
    t_cmd_bus_b();
    t_chain3();
    t_ignored();
    t_quiet();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule